// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in the command path of an SDRAM controller and turns one read or write command into the column addresses of its burst. The start column and bank are given once, together with a one-cycle command strobe. The block sends that column back in the same cycle. It then works out each following column on its own and sends one per clock until the burst length is used up.

The decoded mode fields choose the behaviour. A 3-bit length code sets the burst length. A type bit picks sequential or interleaved ordering. A write-mode bit can force every write down to a single beat, while reads keep the programmed length. A new command strobe may arrive at any point in a burst. It drops the old burst and starts a new one from the new column.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted, and until the first command strobe after reset, `out_valid` and `out_last` are 0.
- R2: In the cycle `cmd_stb` is 1, `out_valid` is 1, `out_col` equals `start_col` and `out_bank` equals `cmd_bank`. The bank stays the same for every later beat of that burst.
- R3: The length code `mode_blen` sets the burst length: 3'b000 is 1 beat, 3'b001 is 2, 3'b010 is 4, 3'b011 is 8 and 3'b111 is a full page of 2^COL_W beats. Codes 3'b100, 3'b101 and 3'b110 act as 1 beat. `out_valid` stays high for exactly that many cycles in a row.
- R4: With `mode_ilv`=0 and a burst of N beats, beat k puts out a column whose bits above log2(N) come from `start_col` and whose low log2(N) bits are (start_col + k) mod N.
- R5: With `mode_ilv`=1 and N of 2, 4 or 8, beat k keeps the upper bits of `start_col` and sets the low log2(N) bits to the low bits of `start_col` XOR k.
- R6: A full-page burst always counts upward (start_col + k) mod 2^COL_W, whatever `mode_ilv` is. It wraps from the top column to column 0 and lasts 2^COL_W beats.
- R7: `out_last` is 1 on the final beat of a burst and on no other cycle.
- R8: When `mode_single_wr`=1, a write command (`cmd_wr`=1) gives exactly one beat at `start_col`, whatever the length code. Reads still use the programmed length. With `mode_single_wr`=0, writes use the programmed length.
- R9: A command strobe during a burst ends that burst at once. The same cycle becomes beat 0 of a new burst, which uses the new column, bank and modes.
- R10: In the cycle after a final beat, `out_valid` is 0 unless a new command strobe is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | One-cycle strobe of a read or write command |
| cmd_wr | input | 1 | 1 = write command, 0 = read command |
| start_col | input | COL_W | Start column given with the command |
| cmd_bank | input | BANK_W | Bank given with the command |
| mode_blen | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = sequential order |
| mode_single_wr | input | 1 | 1 = writes are single beat |
| out_col | output | COL_W | Column of the current beat |
| out_bank | output | BANK_W | Bank of the current beat |
| out_valid | output | 1 | A beat is present this cycle |
| out_last | output | 1 | This beat is the final one of its burst |

## Verification
The bench builds the block with COL_W=8 and BANK_W=2. A full-page burst is then 256 beats, so the wrap from column 255 to column 0 and the final-beat flag at the far end are both checked beat by beat. Start columns are random across all 256 values, and the length codes are random over all eight codes, the unused ones included. As a result, bursts of every length begin at unaligned offsets and wrap inside their block. Some bursts are cut short by a new command, which exercises the restart path from any beat count.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;

  typedef enum logic [2:0] {
    BLEN_1    = 3'b000,
    BLEN_2    = 3'b001,
    BLEN_4    = 3'b010,
    BLEN_8    = 3'b011,
    BLEN_PAGE = 3'b111
  } blen_code_e;

  // Wrap mask for the fixed lengths: N-1, as an all-ones field.
  function automatic logic [2:0] fixed_wrap_mask(input logic [2:0] code);
    logic [2:0] m;
    case (code)
      BLEN_2:  m = 3'b001;
      BLEN_4:  m = 3'b011;
      BLEN_8:  m = 3'b111;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sbcg_len_decode.sv
module sbcg_len_decode #(
  parameter int COL_W = 8
) (
  input  logic [2:0]       blen,
  input  logic             ilv,
  input  logic             single_wr,
  input  logic             is_wr,
  output logic [COL_W-1:0] wrap_mask,
  output logic             ilv_eff
);
  import sbcg_pkg::*;

  logic page_sel;
  logic one_beat_wr;

  always_comb begin
    page_sel    = (blen == BLEN_PAGE);
    one_beat_wr = is_wr && single_wr;
    if (one_beat_wr) begin
      wrap_mask = '0;
    end else if (page_sel) begin
      wrap_mask = '1;
    end else begin
      wrap_mask = COL_W'(fixed_wrap_mask(blen));
    end
    // full page always counts upward
    ilv_eff = ilv && !page_sel && !one_beat_wr;
  end

endmodule

// File: rtl/sbcg_beat_ctr.sv
module sbcg_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] mask_in,
  output logic             active,
  output logic [COL_W-1:0] cnt,
  output logic [COL_W-1:0] mask_q,
  output logic             beat_valid,
  output logic             beat_last
);

  logic             active_q, active_n;
  logic [COL_W-1:0] cnt_q, cnt_n;
  logic [COL_W-1:0] mask_r, mask_n;
  logic             final_beat;

  always_comb begin
    final_beat = active_q && (cnt_q == mask_r);
    active_n   = active_q;
    cnt_n      = cnt_q;
    mask_n     = mask_r;
    if (start) begin
      active_n = (mask_in != '0);
      cnt_n    = COL_W'(1);
      mask_n   = mask_in;
    end else if (active_q) begin
      if (final_beat) begin
        active_n = 1'b0;
      end else begin
        cnt_n = cnt_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mask_r   <= '0;
    end else begin
      active_q <= active_n;
      if (start || active_q) begin
        cnt_q <= cnt_n;
      end
      if (start) begin
        mask_r <= mask_n;
      end
    end
  end

  always_comb begin
    active     = active_q;
    cnt        = cnt_q;
    mask_q     = mask_r;
    beat_valid = start || active_q;
    beat_last  = start ? (mask_in == '0) : final_beat;
  end

  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q != '0) && (cnt_q <= mask_r));

  a_r7_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  a_r10_stop_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    (final_beat && !start) |=> !active_q);

endmodule

// File: rtl/sbcg_addr_form.sv
module sbcg_addr_form #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] step,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_addr;
  logic [COL_W-1:0] ilv_addr;
  logic [COL_W-1:0] mixed;

  always_comb begin
    seq_addr = base + step;
    ilv_addr = base ^ step;
    mixed    = ilv ? ilv_addr : seq_addr;
  end

  // Bits inside the wrap field follow the order, bits above it stay fixed.
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = wrap_mask[i] ? mixed[i] : base[i];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic              cmd_wr,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [2:0]        mode_blen,
  input  logic              mode_ilv,
  input  logic              mode_single_wr,
  output logic [COL_W-1:0]  out_col,
  output logic [BANK_W-1:0] out_bank,
  output logic              out_valid,
  output logic              out_last
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[SYNC_STAGES-1];

  logic [COL_W-1:0]  new_mask;
  logic              new_ilv;
  logic [COL_W-1:0]  st_col_q;
  logic [BANK_W-1:0] st_bank_q;
  logic              ilv_q;
  logic              ctr_active;
  logic [COL_W-1:0]  ctr_cnt;
  logic [COL_W-1:0]  mask_q;
  logic              beat_valid;
  logic              beat_last;
  logic [COL_W-1:0]  af_base;
  logic [COL_W-1:0]  af_step;
  logic [COL_W-1:0]  af_mask;
  logic              af_ilv;
  logic [COL_W-1:0]  af_col;

  sbcg_len_decode #(.COL_W(COL_W)) u_dec (
    .blen      (mode_blen),
    .ilv       (mode_ilv),
    .single_wr (mode_single_wr),
    .is_wr     (cmd_wr),
    .wrap_mask (new_mask),
    .ilv_eff   (new_ilv)
  );

  sbcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (cmd_stb),
    .mask_in    (new_mask),
    .active     (ctr_active),
    .cnt        (ctr_cnt),
    .mask_q     (mask_q),
    .beat_valid (beat_valid),
    .beat_last  (beat_last)
  );

  // Command context, loaded only on the strobe.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_col_q  <= '0;
      st_bank_q <= '0;
      ilv_q     <= 1'b0;
    end else if (cmd_stb) begin
      st_col_q  <= start_col;
      st_bank_q <= cmd_bank;
      ilv_q     <= new_ilv;
    end
  end

  always_comb begin
    if (cmd_stb) begin
      af_base = start_col;
      af_step = '0;
      af_mask = new_mask;
      af_ilv  = new_ilv;
    end else begin
      af_base = st_col_q;
      af_step = ctr_cnt;
      af_mask = mask_q;
      af_ilv  = ilv_q;
    end
  end

  sbcg_addr_form #(.COL_W(COL_W)) u_addr (
    .base      (af_base),
    .step      (af_step),
    .wrap_mask (af_mask),
    .ilv       (af_ilv),
    .col       (af_col)
  );

  always_comb begin
    out_col   = af_col;
    out_bank  = cmd_stb ? cmd_bank : st_bank_q;
    out_valid = beat_valid && rst_n_s;
    out_last  = beat_last && rst_n_s;
  end

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_stb |-> out_valid && (out_col == start_col) && (out_bank == cmd_bank));

  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_last && !cmd_stb) |=> cmd_stb || (out_valid && $stable(out_bank)));

  a_r4_upper_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctr_active && !cmd_stb) |-> (((out_col ^ st_col_q) & ~mask_q) == '0));

  a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_stb && cmd_wr && mode_single_wr) |-> out_last);

  a_r10_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && out_last) |=> (cmd_stb || !out_valid));

endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
  localparam int COL_W  = 8;
  localparam int BANK_W = 2;
  localparam time CLK_PERIOD = 10ns;
  localparam int PAGE = 1 << COL_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_stb;
  logic              cmd_wr;
  logic [COL_W-1:0]  start_col;
  logic [BANK_W-1:0] cmd_bank;
  logic [2:0]        mode_blen;
  logic              mode_ilv;
  logic              mode_single_wr;
  logic [COL_W-1:0]  out_col;
  logic [BANK_W-1:0] out_bank;
  logic              out_valid;
  logic              out_last;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W), .BANK_W(BANK_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_wr(cmd_wr),
    .start_col(start_col), .cmd_bank(cmd_bank), .mode_blen(mode_blen),
    .mode_ilv(mode_ilv), .mode_single_wr(mode_single_wr),
    .out_col(out_col), .out_bank(out_bank), .out_valid(out_valid), .out_last(out_last)
  );

  function automatic int beats_of(input logic [2:0] code, input bit wr, input bit single);
    if (wr && single) return 1;
    case (code)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      3'b111:  return PAGE;
      default: return 1;
    endcase
  endfunction

  function automatic int expect_col(input int start, input int k, input int n, input bit ilv);
    int hi, lo;
    hi = start & ~(n - 1) & (PAGE - 1);
    if (ilv && n != PAGE) lo = (start ^ k) & (n - 1);
    else                  lo = (start + k) & (n - 1);
    return hi | lo;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Issue a command, then check up to `upto` beats (all if upto<=0).
  task automatic burst(input int start, input int bank, input logic [2:0] code,
                       input bit ilv, input bit wr, input bit single, input int upto);
    int n, lim;
    string creq;
    n = beats_of(code, wr, single);
    lim = (upto > 0 && upto < n) ? upto : n;
    if (wr && single)      creq = "R8";
    else if (n == PAGE)    creq = "R6";
    else if (ilv && n > 1) creq = "R5";
    else                   creq = "R4";
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      cmd_stb = (k == 0);
      if (k == 0) begin
        cmd_wr = wr; start_col = COL_W'(start); cmd_bank = BANK_W'(bank);
        mode_blen = code; mode_ilv = ilv; mode_single_wr = single;
      end
      #1;
      check(out_valid === 1'b1, "R3", $sformatf("valid beat %0d", k), int'(out_valid), 1);
      check(int'(out_col) == expect_col(start, k, n, ilv), (k == 0) ? "R2" : creq,
            $sformatf("col beat %0d", k), int'(out_col), expect_col(start, k, n, ilv));
      check(int'(out_bank) == bank, "R2", $sformatf("bank beat %0d", k), int'(out_bank), bank);
      check(out_last === (k == n - 1), "R7", $sformatf("last beat %0d", k), int'(out_last), int'(k == n - 1));
    end
    if (lim == n) begin
      @(negedge clk);
      cmd_stb = 1'b0;
      #1;
      check(out_valid === 1'b0, "R10", "valid after final beat", int'(out_valid), 0);
      check(out_last === 1'b0, "R7", "last after final beat", int'(out_last), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de5));
    rst_n = 1'b0; cmd_stb = 1'b0; cmd_wr = 1'b0; start_col = '0; cmd_bank = '0;
    mode_blen = 3'b000; mode_ilv = 1'b0; mode_single_wr = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    check(out_last === 1'b0, "R1", "last in reset", int'(out_last), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R1", "valid after reset", int'(out_valid), 0);

    // Directed: each length, sequential and interleaved, unaligned starts.
    burst(8'h35, 1, 3'b000, 0, 0, 0, 0);   // R3 length 1
    burst(8'h35, 2, 3'b001, 0, 0, 0, 0);   // R4
    burst(8'h36, 3, 3'b010, 0, 0, 0, 0);   // R4 wrap inside block
    burst(8'h4d, 0, 3'b011, 0, 1, 0, 0);   // R4 write, no single override
    burst(8'h4d, 1, 3'b011, 1, 0, 0, 0);   // R5
    burst(8'h07, 2, 3'b010, 1, 0, 0, 0);   // R5
    burst(8'hfa, 3, 3'b111, 0, 0, 0, 0);   // R6 wrap past 255
    burst(8'h81, 0, 3'b111, 1, 0, 0, 0);   // R6 ilv ignored
    burst(8'h12, 1, 3'b101, 0, 0, 0, 0);   // R3 unused code
    burst(8'h22, 2, 3'b011, 0, 1, 1, 0);   // R8 write single
    burst(8'h22, 2, 3'b111, 0, 1, 1, 0);   // R8 page write single
    burst(8'h22, 3, 3'b011, 1, 0, 1, 0);   // R8 read keeps length
    // R9: restart mid-burst
    burst(8'h40, 1, 3'b011, 0, 0, 0, 3);
    burst(8'h93, 2, 3'b010, 1, 0, 0, 0);
    burst(8'h10, 0, 3'b111, 0, 0, 0, 5);
    burst(8'hc4, 3, 3'b001, 0, 1, 0, 0);

    for (int i = 0; i < 150; i++) begin
      int st, bk, cut;
      logic [2:0] code;
      bit il, wr, sg;
      st   = int'($urandom_range(0, PAGE - 1));
      bk   = int'($urandom_range(0, (1 << BANK_W) - 1));
      code = 3'($urandom_range(0, 7));
      il   = 1'($urandom_range(0, 1));
      wr   = 1'($urandom_range(0, 1));
      sg   = 1'($urandom_range(0, 1));
      cut  = ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 6)) : 0; // R9
      burst(st, bk, code, il, wr, sg, cut);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule